// File: doc/BRIEF.md
# SDRAM Bank Timing Checker

This block sits beside a controller and watches the command bus of a four-bank synchronous DRAM. Each clock it decodes the chip-select, row strobe, column strobe and write enable, together with the bank-select bits and address bit 10. It tracks every bank as idle, open or closing, along with saturating cycle counters. Each row activate, read, write and precharge is judged against the bank state and the spacing rules. The verdict appears one cycle later as a one-hot violation vector that names the single rule that blocks the command.

All timing limits are parameters counted in clock cycles, with nanosecond limits rounded up to whole clocks. A command that breaks a rule is reported and has no effect on the tracked state. A legal command updates the state, so the checker follows the device as the device itself would behave. A read or write issued with address bit 10 high arms a per-bank countdown. That countdown later closes the bank on its own, and the closing is checked like an explicit precharge.

Top module: `sdram_timing_checker`

## Requirements
- R1: Commands decode as {cs_n, ras_n, cas_n, we_n}: activate 0011, read 0101, write 0100, precharge 0010. No-op 0111, burst stop 0110, refresh 0001, mode set 0000 and any command with cs_n high are not checked: `chk_valid_o` stays 0 and no bank state changes.
- R2: One cycle after a checked command, `chk_valid_o` is 1 and `viol_o` is zero if the command is legal. Otherwise `viol_o` has exactly one bit set: the lowest-numbered violated rule in the order 0 auto-precharge busy, 1 bank not open, 2 bank already open, 3 T_RP, 4 T_RC, 5 T_RRD, 6 T_RCD, 7 T_RAS, 8 auto-precharge with full-page bursts.
- R3: A read or write to a bank that is not open flags bit 1. A read or write issued fewer than T_RCD cycles after that bank's activate flags bit 6.
- R4: An activate to an open bank flags bit 2. An activate issued fewer than T_RP cycles after the bank began to close flags bit 3.
- R5: An activate issued fewer than T_RC cycles after the previous activate to the same bank flags bit 4. One issued fewer than T_RRD cycles after any activate flags bit 5.
- R6: A precharge with a10 high targets all banks; with a10 low it targets only bank `ba`. If any targeted open bank was activated fewer than T_RAS cycles earlier, the command flags bit 7. A legal precharge closes the targeted open banks and leaves closed banks unaffected.
- R7: A legal read with a10 high closes its bank BURST_LEN cycles after the command. A legal write with a10 high closes its bank BURST_LEN-1+T_DPL cycles after the command. T_RP is then counted from that point.
- R8: While a bank's automatic close is pending, up to and including the cycle in which it starts, a read, write or precharge that targets that bank flags bit 0.
- R9: A read or write with a10 high whose automatic close would start fewer than T_RAS cycles after the activate flags bit 7.
- R10: With FULL_PAGE set, a read or write with a10 high flags bit 8.
- R11: A flagged command changes no bank state; `bank_open_o` shows each bank's open state.
- R12: After reset all banks are closed, every spacing rule counts as already met, and the outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, low active |
| ras_n | input | 1 | Row strobe, low active |
| cas_n | input | 1 | Column strobe, low active |
| we_n | input | 1 | Write enable, low active |
| ba | input | $clog2(NUM_BANKS) | Bank select |
| a10 | input | 1 | Auto-precharge / all-bank select bit |
| chk_valid_o | output | 1 | A checked command was seen last cycle |
| viol_o | output | 9 | One-hot rule violation for that command |
| bank_open_o | output | NUM_BANKS | Per-bank open state |

## Verification
The hardest situation to reach is the automatic close. Its start cycle is invisible on the command bus, and the busy window, the closing point and the following T_RP window all depend on it. The bench reaches it with an activate, waits the minimum spacing, and issues an auto-precharge read or write. It then sweeps the distance to a re-activate across every cycle until the activate becomes legal, checking `bank_open_o` on every intermediate cycle. Each spacing rule is swept the same way from a fresh reset, and the expected flags come from the parameter arithmetic.

// File: rtl/sdtrk_pkg.sv
`timescale 1ns/1ps
package sdtrk_pkg;

    typedef enum logic [1:0] {BK_IDLE, BK_OPEN, BK_CLOSING} bank_st_e;
    typedef enum logic [2:0] {C_NONE, C_ACT, C_RD, C_WR, C_PRE, C_OTHER} cmd_e;

    localparam int VIOL_W     = 9;
    localparam int V_AP_BUSY  = 0;
    localparam int V_NOT_OPEN = 1;
    localparam int V_IS_OPEN  = 2;
    localparam int V_TRP      = 3;
    localparam int V_TRC      = 4;
    localparam int V_TRRD     = 5;
    localparam int V_TRCD     = 6;
    localparam int V_TRAS     = 7;
    localparam int V_FULLPG   = 8;

    function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                        input logic cas_n, input logic we_n);
        cmd_e c;
        if (cs_n) begin
            c = C_NONE;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b011:  c = C_ACT;
                3'b101:  c = C_RD;
                3'b100:  c = C_WR;
                3'b010:  c = C_PRE;
                3'b111:  c = C_NONE;
                default: c = C_OTHER;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/sdtrk_bank.sv
`timescale 1ns/1ps
module sdtrk_bank
    import sdtrk_pkg::*;
#(
    parameter int T_RCD = 2,
    parameter int T_RC  = 8,
    parameter int T_RP  = 2,
    parameter int T_RAS = 5,
    parameter int CNT_W = 4,
    parameter int AP_W  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            act_i,
    input  logic            rw_i,
    input  logic            pre_i,
    input  logic            ap_i,
    input  logic            commit_i,
    input  logic [AP_W-1:0] ap_delay_i,
    output logic            open_o,
    output logic            busy_o,
    output logic            rcd_ok_o,
    output logic            rc_ok_o,
    output logic            rp_ok_o,
    output logic            ras_ok_o,
    output logic            ras_ap_ok_o
);

    typedef struct packed {
        bank_st_e         st;
        logic [CNT_W-1:0] act_cnt;
        logic [CNT_W-1:0] pre_cnt;
        logic             ap_pend;
        logic [AP_W-1:0]  ap_cnt;
    } bank_s;

    bank_s bank_d, bank_q;
    logic  ap_start;

    assign open_o      = (bank_q.st == BK_OPEN);
    assign busy_o      = bank_q.ap_pend;
    assign rcd_ok_o    = int'(bank_q.act_cnt) >= T_RCD;
    assign rc_ok_o     = int'(bank_q.act_cnt) >= T_RC;
    assign rp_ok_o     = int'(bank_q.pre_cnt) >= T_RP;
    assign ras_ok_o    = int'(bank_q.act_cnt) >= T_RAS;
    assign ras_ap_ok_o = (int'(bank_q.act_cnt) + int'(ap_delay_i)) >= T_RAS;
    assign ap_start    = bank_q.ap_pend && (bank_q.ap_cnt == AP_W'(1));

    always_comb begin
        bank_d = bank_q;
        if (bank_q.act_cnt != '1) bank_d.act_cnt = bank_q.act_cnt + 1'b1;
        if (bank_q.pre_cnt != '1) bank_d.pre_cnt = bank_q.pre_cnt + 1'b1;
        if (bank_q.ap_pend)       bank_d.ap_cnt  = bank_q.ap_cnt - 1'b1;

        if (ap_start) begin
            bank_d.st      = BK_CLOSING;
            bank_d.pre_cnt = CNT_W'(1);
            bank_d.ap_pend = 1'b0;
        end else if (bank_q.st == BK_CLOSING && rp_ok_o) begin
            bank_d.st = BK_IDLE;
        end

        if (commit_i) begin
            if (act_i) begin
                bank_d.st      = BK_OPEN;
                bank_d.act_cnt = CNT_W'(1);
                bank_d.ap_pend = 1'b0;
            end
            if (rw_i && ap_i) begin
                bank_d.ap_pend = 1'b1;
                bank_d.ap_cnt  = ap_delay_i;
            end
            if (pre_i && bank_q.st == BK_OPEN) begin
                bank_d.st      = BK_CLOSING;
                bank_d.pre_cnt = CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q.st      <= BK_IDLE;
            bank_q.act_cnt <= '1;
            bank_q.pre_cnt <= '1;
            bank_q.ap_pend <= 1'b0;
            bank_q.ap_cnt  <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assert_ap_needs_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bank_q.ap_pend |-> (bank_q.st == BK_OPEN));
    assert_rw_after_rcd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && rw_i) |-> (bank_q.st == BK_OPEN && int'(bank_q.act_cnt) >= T_RCD));
    assert_act_after_rp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && act_i) |-> (bank_q.st != BK_OPEN && int'(bank_q.pre_cnt) >= T_RP));

endmodule

// File: rtl/sdtrk_pick.sv
`timescale 1ns/1ps
module sdtrk_pick #(
    parameter int W = 9
) (
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] pick_o
);

    always_comb begin
        logic found;
        found  = 1'b0;
        pick_o = '0;
        for (int i = 0; i < W; i++) begin
            if (raw_i[i] && !found) begin
                pick_o[i] = 1'b1;
                found     = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sdram_timing_checker.sv
`timescale 1ns/1ps
module sdram_timing_checker
    import sdtrk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int T_RCD     = 2,
    parameter int T_RC      = 8,
    parameter int T_RRD     = 2,
    parameter int T_RP      = 2,
    parameter int T_RAS     = 5,
    parameter int T_DPL     = 2,
    parameter int BURST_LEN = 2,
    parameter bit FULL_PAGE = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cs_n,
    input  logic                         ras_n,
    input  logic                         cas_n,
    input  logic                         we_n,
    input  logic [$clog2(NUM_BANKS)-1:0] ba,
    input  logic                         a10,
    output logic                         chk_valid_o,
    output logic [sdtrk_pkg::VIOL_W-1:0] viol_o,
    output logic [NUM_BANKS-1:0]         bank_open_o
);

    localparam int BA_W    = $clog2(NUM_BANKS);
    localparam int MAX_A   = (T_RC > T_RAS) ? T_RC : T_RAS;
    localparam int MAX_B   = (T_RP > T_RRD) ? T_RP : T_RRD;
    localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_MAX = (MAX_C > T_RCD) ? MAX_C : T_RCD;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int AP_W    = $clog2(BURST_LEN + T_DPL + 1);
    localparam logic [AP_W-1:0] RD_AP_DLY = AP_W'(BURST_LEN);
    localparam logic [AP_W-1:0] WR_AP_DLY = AP_W'(BURST_LEN - 1 + T_DPL);

    typedef struct packed {
        logic              valid;
        logic [VIOL_W-1:0] viol;
        logic [CNT_W-1:0]  rrd_cnt;
    } top_s;

    top_s top_d, top_q;
    cmd_e cmd;
    logic is_act, is_rw, is_pre, checked, commit;
    logic [AP_W-1:0]      ap_dly;
    logic [NUM_BANKS-1:0] pre_mask, open_w, busy_w, rcd_ok, rc_ok, rp_ok, ras_ok, ras_ap_ok;
    logic [VIOL_W-1:0]    raw, pick;

    assign cmd     = decode_cmd(cs_n, ras_n, cas_n, we_n);
    assign is_act  = (cmd == C_ACT);
    assign is_rw   = (cmd == C_RD) || (cmd == C_WR);
    assign is_pre  = (cmd == C_PRE);
    assign checked = is_act || is_rw || is_pre;
    assign ap_dly  = (cmd == C_WR) ? WR_AP_DLY : RD_AP_DLY;
    assign commit  = checked && (raw == '0);

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            assign pre_mask[b] = a10 || (ba == BA_W'(b));
            sdtrk_bank #(
                .T_RCD(T_RCD), .T_RC(T_RC), .T_RP(T_RP), .T_RAS(T_RAS),
                .CNT_W(CNT_W), .AP_W(AP_W)
            ) u_bank (
                .clk        (clk),
                .rst_n      (rst_n),
                .act_i      (is_act && ba == BA_W'(b)),
                .rw_i       (is_rw && ba == BA_W'(b)),
                .pre_i      (is_pre && pre_mask[b]),
                .ap_i       (a10),
                .commit_i   (commit),
                .ap_delay_i (ap_dly),
                .open_o     (open_w[b]),
                .busy_o     (busy_w[b]),
                .rcd_ok_o   (rcd_ok[b]),
                .rc_ok_o    (rc_ok[b]),
                .rp_ok_o    (rp_ok[b]),
                .ras_ok_o   (ras_ok[b]),
                .ras_ap_ok_o(ras_ap_ok[b])
            );
        end
    endgenerate

    always_comb begin
        raw             = '0;
        raw[V_AP_BUSY]  = (is_rw && busy_w[ba]) || (is_pre && |(busy_w & pre_mask));
        raw[V_NOT_OPEN] = is_rw && !open_w[ba];
        raw[V_IS_OPEN]  = is_act && open_w[ba];
        raw[V_TRP]      = is_act && !rp_ok[ba];
        raw[V_TRC]      = is_act && !rc_ok[ba];
        raw[V_TRRD]     = is_act && (int'(top_q.rrd_cnt) < T_RRD);
        raw[V_TRCD]     = is_rw && !rcd_ok[ba];
        raw[V_TRAS]     = (is_pre && |(pre_mask & open_w & ~ras_ok))
                        || (is_rw && a10 && !ras_ap_ok[ba]);
        raw[V_FULLPG]   = is_rw && a10 && FULL_PAGE;
    end

    sdtrk_pick #(.W(VIOL_W)) u_pick (
        .raw_i (raw),
        .pick_o(pick)
    );

    always_comb begin
        top_d       = top_q;
        top_d.valid = checked;
        top_d.viol  = pick;
        if (commit && is_act)         top_d.rrd_cnt = CNT_W'(1);
        else if (top_q.rrd_cnt != '1) top_d.rrd_cnt = top_q.rrd_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q.valid   <= 1'b0;
            top_q.viol    <= '0;
            top_q.rrd_cnt <= '1;
        end else begin
            top_q <= top_d;
        end
    end

    assign chk_valid_o = top_q.valid;
    assign viol_o      = top_q.viol;
    assign bank_open_o = open_w;

    assert_viol_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(viol_o));
    assert_viol_needs_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_o != '0) |-> chk_valid_o);
    assert_closed_rw_flagged_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rw && !open_w[ba]) |=> (viol_o != '0));
    assert_busy_blocks_rw_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rw && busy_w[ba]) |=> viol_o[V_AP_BUSY]);
    assert_unchecked_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!checked) |=> !chk_valid_o);

endmodule

// File: tb/sdram_timing_checker_tb.sv
`timescale 1ns/1ps
module sdram_timing_checker_tb_top;

    localparam logic [3:0] K_ACT = 4'b0011, K_RD = 4'b0101, K_WR = 4'b0100,
                           K_PRE = 4'b0010, K_NOP = 4'b0111, K_DES = 4'b1111,
                           K_BST = 4'b0110, K_REF = 4'b0001, K_MRS = 4'b0000;
    localparam int T_RCD = 2, T_RC = 8, T_RRD = 2, T_RP = 2, T_RAS = 5;
    localparam int T_DPL = 2, BL = 2;
    localparam int NONE = -1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = '0;
    logic a10 = 1'b0;
    logic       chk_valid, fp_valid;
    logic [8:0] viol, fp_viol;
    logic [3:0] bank_open, fp_open;
    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    sdram_timing_checker dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .a10(a10),
        .chk_valid_o(chk_valid), .viol_o(viol), .bank_open_o(bank_open)
    );

    sdram_timing_checker #(.FULL_PAGE(1'b1)) dut_fp_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .a10(a10),
        .chk_valid_o(fp_valid), .viol_o(fp_viol), .bank_open_o(fp_open)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic [9:0] verdict(input int bitn);
        return {1'b1, (bitn < 0) ? 9'd0 : 9'(1 << bitn)};
    endfunction

    task automatic cyc(input logic [3:0] c, input int b, input logic ap);
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = c;
        ba  = 2'(b);
        a10 = ap;
        @(posedge clk);
        #1;
    endtask

    task automatic nops(input int n);
        for (int i = 0; i < n; i++) cyc(K_NOP, 0, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {cs_n, ras_n, cas_n, we_n} = K_NOP;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        check("R12 reset outputs", {chk_valid, viol, bank_open}, 14'd0);

        // R1: unchecked commands leave everything quiet
        cyc(K_ACT, 0, 1'b0);
        foreach (K_LIST[i]) begin
            cyc(K_LIST[i], 0, 1'b0);
            check("R1 unchecked command", {chk_valid, viol, bank_open}, {10'd0, 4'b0001});
        end

        // R3: T_RCD sweep over all banks, reads and writes
        for (int b = 0; b < 4; b++) begin
            for (int k = 1; k <= 4; k++) begin
                do_reset();
                cyc(K_ACT, b, 1'b0);
                nops(k - 1);
                cyc((k % 2) ? K_RD : K_WR, b, 1'b0);
                check("R3 trcd", {chk_valid, viol}, verdict(k < T_RCD ? 6 : NONE));
            end
        end

        // R5: T_RRD between banks; R11 illegal activate leaves bank closed
        for (int k = 1; k <= 3; k++) begin
            do_reset();
            cyc(K_ACT, 0, 1'b0);
            nops(k - 1);
            cyc(K_ACT, 1, 1'b0);
            check("R5 trrd", {chk_valid, viol}, verdict(k < T_RRD ? 5 : NONE));
            check("R11 act state", 32'(bank_open[1]), 32'(k >= T_RRD));
        end

        // R4/R5: T_RP then T_RC after explicit precharge at cycle T_RAS
        for (int k = T_RAS + 1; k <= T_RAS + 4; k++) begin
            do_reset();
            cyc(K_ACT, 2, 1'b0);
            nops(T_RAS - 1);
            cyc(K_PRE, 2, 1'b0);
            check("R6 legal precharge", {chk_valid, viol, bank_open}, {verdict(NONE), 4'b0000});
            nops(k - T_RAS - 1);
            cyc(K_ACT, 2, 1'b0);
            check("R4 R5 trp trc", {chk_valid, viol},
                  verdict((k - T_RAS < T_RP) ? 3 : (k < T_RC) ? 4 : NONE));
        end

        // R6/R11: T_RAS sweep on single precharge
        for (int k = 1; k <= 6; k++) begin
            do_reset();
            cyc(K_ACT, 1, 1'b0);
            nops(k - 1);
            cyc(K_PRE, 1, 1'b0);
            check("R6 tras", {chk_valid, viol}, verdict(k < T_RAS ? 7 : NONE));
            check("R11 precharge state", 32'(bank_open[1]), 32'(k < T_RAS));
        end

        // R6: precharge all, one bank too young
        do_reset();
        cyc(K_ACT, 0, 1'b0);
        nops(1);
        cyc(K_ACT, 2, 1'b0);
        nops(2);
        cyc(K_PRE, 3, 1'b1);
        check("R6 all-bank tras", {chk_valid, viol, bank_open}, {verdict(7), 4'b0101});
        cyc(K_PRE, 0, 1'b1);
        check("R6 all-bank tras again", {chk_valid, viol, bank_open}, {verdict(7), 4'b0101});
        cyc(K_PRE, 0, 1'b1);
        check("R6 all-bank legal", {chk_valid, viol, bank_open}, {verdict(NONE), 4'b0000});

        // R6: single precharge touches only ba; closed bank unaffected
        do_reset();
        cyc(K_ACT, 1, 1'b0);
        nops(5);
        cyc(K_PRE, 3, 1'b0);
        check("R6 single target", {chk_valid, viol, bank_open}, {verdict(NONE), 4'b0010});

        // R2/R4/R3: priority and state rules
        do_reset();
        cyc(K_ACT, 0, 1'b0);
        cyc(K_ACT, 0, 1'b0);
        check("R2 R4 priority open", {chk_valid, viol}, verdict(2));
        cyc(K_RD, 3, 1'b0);
        check("R3 closed read", {chk_valid, viol}, verdict(1));

        // R7/R4: auto-precharge close point and re-activate spacing
        for (int w = 0; w < 2; w++) begin
            int d;
            d = w ? (BL - 1 + T_DPL) : BL;
            for (int k = 1; k <= d + T_RP + 2; k++) begin
                do_reset();
                cyc(K_ACT, 1, 1'b0);
                nops(2);
                cyc(w ? K_WR : K_RD, 1, 1'b1);
                check("R7 ap issue", {chk_valid, viol}, verdict(NONE));
                for (int t = 4; t < 3 + k; t++) begin
                    cyc(K_NOP, 0, 1'b0);
                    check("R7 close point", 32'(bank_open[1]), 32'(t < 3 + d));
                end
                cyc(K_ACT, 1, 1'b0);
                check("R7 R4 reopen", {chk_valid, viol},
                      verdict((k <= d) ? 2 : (k - d < T_RP) ? 3 : (3 + k < T_RC) ? 4 : NONE));
            end
        end

        // R8: busy window on the pending bank
        do_reset();
        cyc(K_ACT, 3, 1'b0);
        nops(2);
        cyc(K_WR, 3, 1'b1);
        cyc(K_PRE, 3, 1'b0);
        check("R8 busy precharge", {chk_valid, viol}, verdict(0));
        cyc(K_RD, 3, 1'b0);
        check("R8 busy read", {chk_valid, viol}, verdict(0));
        cyc(K_PRE, 0, 1'b1);
        check("R8 busy all-bank at start cycle", {chk_valid, viol}, verdict(0));
        cyc(K_RD, 3, 1'b0);
        check("R8 after close", {chk_valid, viol}, verdict(1));

        // R9: auto-precharge start versus T_RAS
        for (int w = 0; w < 2; w++) begin
            for (int g = 2; g <= 3; g++) begin
                int d;
                d = w ? (BL - 1 + T_DPL) : BL;
                do_reset();
                cyc(K_ACT, 0, 1'b0);
                nops(g - 1);
                cyc(w ? K_WR : K_RD, 0, 1'b1);
                check("R9 ap tras", {chk_valid, viol}, verdict((g + d < T_RAS) ? 7 : NONE));
            end
        end

        // R10: full-page configuration rejects auto-precharge
        do_reset();
        cyc(K_ACT, 0, 1'b0);
        nops(2);
        cyc(K_RD, 0, 1'b1);
        check("R10 full page ap", {fp_valid, fp_viol}, verdict(8));
        check("R10 normal config ap", {chk_valid, viol}, verdict(NONE));
        cyc(K_WR, 0, 1'b0);
        check("R10 full page plain write", {fp_valid, fp_viol}, verdict(NONE));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    localparam logic [3:0] K_LIST [5] = '{K_NOP, K_DES, K_BST, K_REF, K_MRS};

endmodule